// File: doc/BRIEF.md
# Checked Endian-Configurable Load/Store Port

This block is the data-side memory front end of a small processor core. It takes one byte, halfword or word access per cycle, checks the address first against a configurable memory bound and then against natural alignment, and steers data across four byte lanes. A runtime input selects big-endian or little-endian lane order. A single-port byte-lane RAM sits inside the block. A response carrying read data comes back one cycle after each accepted request.

A failed check blocks the write and forces the read data to zero. It also loads a sticky two-bit fault code, which holds until software-facing logic pulses a clear input. The range bound `LIMIT_BYTES` defaults to 2^23 bytes. The physical storage holds `4 * 2**STORE_AW` bytes. Any in-range address beyond the storage size wraps onto it, which keeps elaboration small while the bound still follows the memory map.

Top module: `chk_mem_port`

## Requirements
- R1: `req_ready` is always 1. Every cycle with `req_valid` high produces `rsp_valid` high in the next cycle, and a cycle without a request produces `rsp_valid` low in the next cycle.
- R2: An access whose unsigned address is greater than or equal to `LIMIT_BYTES` sets fault code 01 and leaves memory unchanged.
- R3: An in-range access that is misaligned sets fault code 10 and leaves memory unchanged. A word access is misaligned when address bits [1:0] are nonzero, and a halfword access when bit 0 is 1. Size encoding is 00 byte, 01 halfword, 10 word, and 11 is handled as a word.
- R4: An access that is both out of range and misaligned reports only code 01.
- R5: A faulting read returns data 0, and every write response returns data 0.
- R6: With `big_endian`=1, the most significant byte of a halfword or word sits at the lowest address.
- R7: With `big_endian`=0, the least significant byte sits at the lowest address.
- R8: A byte write stores only `req_wdata[7:0]` and a halfword write stores only `req_wdata[15:0]`. The other bytes of the word are kept, and byte and halfword reads are zero-extended.
- R9: The fault code is sticky. Once it is nonzero and no clear is given, it keeps its value through later good or faulting accesses, and it is never 11.
- R10: A cycle with `fault_clear` high returns the code to 00 at the next edge. If a faulting request arrives in that same cycle, its code is recorded instead.
- R11: Reset (synchronous, active high) drives `rsp_valid` to 0 and the fault code to 00.
- R12: An in-range address reaches the storage byte at address modulo `4*2**STORE_AW`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| big_endian | input | 1 | 1 = big-endian lane order, 0 = little-endian |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Always 1 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data, low-aligned |
| rsp_valid | output | 1 | Response present, one cycle after request |
| rsp_data | output | 32 | Zero-extended read data, 0 on fault or write |
| fault_code | output | 2 | Sticky: 00 none, 01 range, 10 alignment |
| fault_clear | input | 1 | Pulse to clear the fault code |

## Verification
The bench writes known words and reads them back in both lane orders at every width. This separates a swapped lane order from a wrong lane choice. It then mixes halfword and byte writes of wide data into known words, which would expose spills into neighbouring bytes. Addresses just below and at a bound that is not a power of two tell apart the range check, the alignment check and their priority. A write beyond storage but inside the bound shows the wrap-around. Paired faults with and without a clear pulse distinguish the first-fault-held rule from a last-fault-wins design.

// File: rtl/chkmem_pkg.sv
package chkmem_pkg;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'b00,
    FLT_RANGE = 2'b01,
    FLT_ALIGN = 2'b10
  } fault_e;

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;

  typedef struct packed {
    logic       write;
    logic [1:0] size;
    logic       big;
    logic [1:0] offs;
  } acc_ctl_t;

  function automatic logic is_word(input logic [1:0] sz);
    return sz[1];
  endfunction

endpackage

// File: rtl/chkmem_check.sv
module chkmem_check
  import chkmem_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LIMIT_BYTES = 2**23
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output fault_e            flt
);
  localparam logic [ADDR_W:0] LIMIT_V = (ADDR_W+1)'(LIMIT_BYTES);

  logic out_of_range;
  logic misaligned;

  always_comb begin
    out_of_range = {1'b0, addr} >= LIMIT_V;
    if (is_word(size))        misaligned = addr[1:0] != 2'b00;
    else if (size == SZ_HALF) misaligned = addr[0];
    else                      misaligned = 1'b0;
    // range outranks alignment
    if (out_of_range)    flt = FLT_RANGE;
    else if (misaligned) flt = FLT_ALIGN;
    else                 flt = FLT_NONE;
  end
endmodule

// File: rtl/chkmem_lanes.sv
module chkmem_lanes
  import chkmem_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [1:0]         size,
  input  logic [1:0]         offs,
  input  logic               big,
  input  logic [8*LANES-1:0] wdata,
  output logic [LANES-1:0]   mask,
  output logic [8*LANES-1:0] lane_data
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam logic [1:0] LN = 2'(k);
    always_comb begin
      if (is_word(size)) begin
        mask[k] = 1'b1;
        lane_data[8*k +: 8] = big ? wdata[8*(LANES-1-k) +: 8] : wdata[8*k +: 8];
      end else if (size == SZ_HALF) begin
        mask[k] = LN[1] == offs[1];
        if (!LN[0]) lane_data[8*k +: 8] = big ? wdata[15:8] : wdata[7:0];
        else        lane_data[8*k +: 8] = big ? wdata[7:0]  : wdata[15:8];
      end else begin
        mask[k] = LN == offs;
        lane_data[8*k +: 8] = wdata[7:0];
      end
    end
  end
endmodule

// File: rtl/chkmem_store.sv
module chkmem_store #(
  parameter int AW    = 10,
  parameter int LANES = 4
) (
  input  logic               clk,
  input  logic [LANES-1:0]   we,
  input  logic [AW-1:0]      idx,
  input  logic [8*LANES-1:0] wbytes,
  output logic [8*LANES-1:0] q
);
  localparam int DEPTH = 2**AW;

  for (genvar k = 0; k < LANES; k++) begin : g_bank
    logic [7:0] bank [DEPTH];
    always_ff @(posedge clk) begin
      if (we[k]) bank[idx] <= wbytes[8*k +: 8];
      q[8*k +: 8] <= bank[idx];
    end
  end
endmodule

// File: rtl/chkmem_gather.sv
module chkmem_gather
  import chkmem_pkg::*;
(
  input  acc_ctl_t    ctl,
  input  logic        faulted,
  input  logic [31:0] q,
  output logic [31:0] data
);
  logic [7:0] first_b;
  logic [7:0] second_b;

  always_comb begin
    first_b  = q[{ctl.offs[1], 1'b0, 3'b000} +: 8];
    second_b = q[{ctl.offs[1], 1'b1, 3'b000} +: 8];
    if (faulted || ctl.write)
      data = '0;
    else if (is_word(ctl.size))
      data = ctl.big ? {q[7:0], q[15:8], q[23:16], q[31:24]} : q;
    else if (ctl.size == SZ_HALF)
      data = ctl.big ? {16'h0, first_b, second_b} : {16'h0, second_b, first_b};
    else
      data = {24'h0, q[{ctl.offs, 3'b000} +: 8]};
  end
endmodule

// File: rtl/chk_mem_port.sv
module chk_mem_port
  import chkmem_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LIMIT_BYTES = 2**23,
  parameter int STORE_AW    = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              big_endian,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_data,
  output logic [1:0]        fault_code,
  input  logic              fault_clear
);
  localparam int LANES  = 4;
  localparam int IDX_HI = STORE_AW + 1;

  fault_e             flt;
  logic [LANES-1:0]   lane_mask;
  logic [31:0]        lane_bytes;
  logic [LANES-1:0]   we;
  logic [31:0]        store_q;
  acc_ctl_t           ctl_q;
  logic               flt_q;
  logic               rsp_valid_q;
  fault_e             code_q;

  assign req_ready = 1'b1;

  chkmem_check #(.ADDR_W(ADDR_W), .LIMIT_BYTES(LIMIT_BYTES)) u_check (
    .addr (req_addr),
    .size (req_size),
    .flt  (flt)
  );

  chkmem_lanes #(.LANES(LANES)) u_lanes (
    .size      (req_size),
    .offs      (req_addr[1:0]),
    .big       (big_endian),
    .wdata     (req_wdata),
    .mask      (lane_mask),
    .lane_data (lane_bytes)
  );

  assign we = (req_valid && req_write && flt == FLT_NONE) ? lane_mask : '0;

  chkmem_store #(.AW(STORE_AW), .LANES(LANES)) u_store (
    .clk    (clk),
    .we     (we),
    .idx    (req_addr[IDX_HI:2]),
    .wbytes (lane_bytes),
    .q      (store_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_q <= 1'b0;
      ctl_q       <= '0;
      flt_q       <= 1'b0;
      code_q      <= FLT_NONE;
    end else begin
      rsp_valid_q <= req_valid;
      if (req_valid) begin
        ctl_q <= '{write: req_write, size: req_size, big: big_endian, offs: req_addr[1:0]};
        flt_q <= flt != FLT_NONE;
      end
      if (req_valid && flt != FLT_NONE && (code_q == FLT_NONE || fault_clear))
        code_q <= flt;
      else if (fault_clear)
        code_q <= FLT_NONE;
    end
  end

  chkmem_gather u_gather (
    .ctl     (ctl_q),
    .faulted (flt_q),
    .q       (store_q),
    .data    (rsp_data)
  );

  assign rsp_valid  = rsp_valid_q;
  assign fault_code = code_q;
endmodule

// File: rtl/chk_mem_port_sva.sv
module chk_mem_port_sva #(
  parameter int ADDR_W      = 32,
  parameter int LIMIT_BYTES = 2**23
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic [1:0]        req_size,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic [31:0]       rsp_data,
  input logic [1:0]        fault_code,
  input logic              fault_clear
);
  logic oor;
  assign oor = {1'b0, req_addr} >= (ADDR_W+1)'(LIMIT_BYTES);

  p_rsp_follows_r1: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  p_rsp_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  p_range_code_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && oor && fault_code == 2'b00) |=> fault_code == 2'b01);
  p_align_code_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !oor && req_size[1] && req_addr[1:0] != 2'b00 && fault_code == 2'b00)
      |=> fault_code == 2'b10);
  p_range_first_r4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && oor && req_size != 2'b00 && req_addr[0] && fault_code == 2'b00)
      |=> fault_code == 2'b01);
  p_fault_rd_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && oor) |=> rsp_data == 32'h0);
  p_wr_rsp_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write) |=> rsp_data == 32'h0);
  p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (fault_code != 2'b00 && !fault_clear) |=> $stable(fault_code));
  p_code_legal_r9: assert property (@(posedge clk) disable iff (rst)
    fault_code != 2'b11);
  p_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (fault_clear && !req_valid) |=> fault_code == 2'b00);
  p_reset_r11: assert property (@(posedge clk)
    rst |=> (!rsp_valid && fault_code == 2'b00));
endmodule

bind chk_mem_port chk_mem_port_sva #(.ADDR_W(ADDR_W), .LIMIT_BYTES(LIMIT_BYTES)) u_sva (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_write   (req_write),
  .req_size    (req_size),
  .req_addr    (req_addr),
  .rsp_valid   (rsp_valid),
  .rsp_data    (rsp_data),
  .fault_code  (fault_code),
  .fault_clear (fault_clear)
);

// File: tb/sim_chk_mem_port.sv
module sim_chk_mem_port;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 6000;
  localparam int SAW        = 10;

  typedef struct packed {
    logic        wr;
    logic [1:0]  sz;
    logic        be;
    logic [31:0] addr;
    logic [31:0] wd;
    logic [31:0] exp;
    logic [1:0]  ef;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 32;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd2, 1'b1, 32'h10,   32'h11223344, 32'h0,        2'd0, 4'd6},  // R6 write
    '{1'b0, 2'd2, 1'b1, 32'h10,   32'h0,        32'h11223344, 2'd0, 4'd6},  // R6
    '{1'b0, 2'd2, 1'b0, 32'h10,   32'h0,        32'h44332211, 2'd0, 4'd7},  // R7
    '{1'b0, 2'd0, 1'b1, 32'h10,   32'h0,        32'h11,       2'd0, 4'd6},  // R6 byte
    '{1'b0, 2'd0, 1'b0, 32'h13,   32'h0,        32'h44,       2'd0, 4'd7},  // R7 byte
    '{1'b0, 2'd1, 1'b1, 32'h12,   32'h0,        32'h3344,     2'd0, 4'd6},  // R6 half
    '{1'b0, 2'd1, 1'b0, 32'h12,   32'h0,        32'h4433,     2'd0, 4'd7},  // R7 half
    '{1'b1, 2'd2, 1'b1, 32'h20,   32'h01020304, 32'h0,        2'd0, 4'd6},  // R6
    '{1'b1, 2'd1, 1'b0, 32'h20,   32'hAABBCCDD, 32'h0,        2'd0, 4'd8},  // R8 half LE
    '{1'b0, 2'd2, 1'b1, 32'h20,   32'h0,        32'hDDCC0304, 2'd0, 4'd8},  // R8
    '{1'b1, 2'd0, 1'b1, 32'h23,   32'h55667788, 32'h0,        2'd0, 4'd8},  // R8 byte
    '{1'b0, 2'd2, 1'b0, 32'h20,   32'h0,        32'h8803CCDD, 2'd0, 4'd8},  // R8
    '{1'b1, 2'd1, 1'b1, 32'h22,   32'h0000BEEF, 32'h0,        2'd0, 4'd8},  // R8 half BE
    '{1'b0, 2'd2, 1'b1, 32'h20,   32'h0,        32'hDDCCBEEF, 2'd0, 4'd8},  // R8
    '{1'b1, 2'd2, 1'b0, 32'h30,   32'hA1B2C3D4, 32'h0,        2'd0, 4'd7},  // R7 write
    '{1'b0, 2'd2, 1'b1, 32'h30,   32'h0,        32'hD4C3B2A1, 2'd0, 4'd7},  // R7
    '{1'b1, 2'd2, 1'b1, 32'h770,  32'hCAFEF00D, 32'h0,        2'd0, 4'd2},  // R2 setup
    '{1'b1, 2'd2, 1'b1, 32'h1770, 32'h0BADBEEF, 32'h0,        2'd1, 4'd2},  // R2 blocked
    '{1'b0, 2'd2, 1'b1, 32'h770,  32'h0,        32'hCAFEF00D, 2'd0, 4'd2},  // R2 unchanged
    '{1'b0, 2'd2, 1'b1, 32'h1770, 32'h0,        32'h0,        2'd1, 4'd2},  // R2 at bound
    '{1'b1, 2'd2, 1'b1, 32'h176C, 32'h12345678, 32'h0,        2'd0, 4'd12}, // R12 wrap
    '{1'b0, 2'd2, 1'b1, 32'h76C,  32'h0,        32'h12345678, 2'd0, 4'd12}, // R12
    '{1'b0, 2'd2, 1'b1, 32'h11,   32'h0,        32'h0,        2'd2, 4'd5},  // R5 R3
    '{1'b1, 2'd1, 1'b1, 32'h771,  32'h0000FFFF, 32'h0,        2'd2, 4'd3},  // R3 blocked
    '{1'b0, 2'd2, 1'b1, 32'h770,  32'h0,        32'hCAFEF00D, 2'd0, 4'd3},  // R3 unchanged
    '{1'b0, 2'd3, 1'b1, 32'h12,   32'h0,        32'h0,        2'd2, 4'd3},  // R3 size 11
    '{1'b0, 2'd2, 1'b1, 32'h176F, 32'h0,        32'h0,        2'd2, 4'd4},  // R4 below bound
    '{1'b0, 2'd2, 1'b1, 32'h1771, 32'h0,        32'h0,        2'd1, 4'd4},  // R4 both
    '{1'b0, 2'd0, 1'b1, 32'hFFFFFFFF, 32'h0,    32'h0,        2'd1, 4'd4},  // R4 top
    '{1'b0, 2'd1, 1'b0, 32'h1773, 32'h0,        32'h0,        2'd1, 4'd4},  // R4 half
    '{1'b0, 2'd1, 1'b0, 32'h176E, 32'h0,        32'h7856,     2'd0, 4'd12}, // R12 LE half
    '{1'b0, 2'd0, 1'b1, 32'h22,   32'h0,        32'hBE,       2'd0, 4'd8}   // R8 zero-ext
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        big_endian = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic [1:0]  fault_code;
  logic        fault_clear = 1'b0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chk_mem_port #(.ADDR_W(32), .LIMIT_BYTES(LIMIT), .STORE_AW(SAW)) u0 (
    .clk(clk), .rst(rst), .big_endian(big_endian), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_size(req_size),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .fault_code(fault_code), .fault_clear(fault_clear)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic w, input logic [1:0] sz, input logic be,
                       input logic [31:0] a, input logic [31:0] wd, input logic clr);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_size = sz; big_endian = be;
    req_addr = a; req_wdata = wd; fault_clear = clr;
    @(negedge clk);
    req_valid = 1'b0; fault_clear = 1'b0;
  endtask

  task automatic pulse_clear();
    @(negedge clk);
    fault_clear = 1'b1;
    @(negedge clk);
    fault_clear = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000 && !done) begin
        done = 1'b1;
        errors++;
        $display("FAIL watchdog actual %0d expected below 20000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 rsp_valid in reset", 32'(rsp_valid), 32'h0);
    check("R11 fault in reset", 32'(fault_code), 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 ready", 32'(req_ready), 32'h1);
    check("R1 idle no response", 32'(rsp_valid), 32'h0);

    for (int i = 0; i < NV; i++) begin
      issue(VECS[i].wr, VECS[i].sz, VECS[i].be, VECS[i].addr, VECS[i].wd, 1'b0);
      check($sformatf("R1 vec %0d valid", i), 32'(rsp_valid), 32'h1);
      check($sformatf("R%0d vec %0d data", VECS[i].rq, i), rsp_data, VECS[i].exp);
      check($sformatf("R%0d vec %0d fault", VECS[i].rq, i), 32'(fault_code), 32'(VECS[i].ef));
      if (VECS[i].ef != 2'd0) begin
        pulse_clear();
        check($sformatf("R10 vec %0d cleared", i), 32'(fault_code), 32'h0);
      end
    end

    @(negedge clk);
    check("R1 idle after traffic", 32'(rsp_valid), 32'h0);

    // R9: first fault held across a later fault and a good access
    issue(1'b0, 2'd2, 1'b1, 32'h2000, 32'h0, 1'b0);
    issue(1'b0, 2'd2, 1'b1, 32'h11, 32'h0, 1'b0);
    check("R9 first fault held", 32'(fault_code), 32'h1);
    issue(1'b0, 2'd2, 1'b1, 32'h10, 32'h0, 1'b0);
    check("R9 good read data", rsp_data, 32'h11223344);
    check("R9 held after good access", 32'(fault_code), 32'h1);

    // R10: clear with a faulting request records the new fault
    issue(1'b0, 2'd1, 1'b1, 32'h13, 32'h0, 1'b1);
    check("R10 clear plus fault", 32'(fault_code), 32'h2);
    issue(1'b0, 2'd0, 1'b1, 32'h10, 32'h0, 1'b1);
    check("R10 clear with good access", 32'(fault_code), 32'h0);
    check("R10 good access data", rsp_data, 32'h11);

    // R11: reset mid-run
    issue(1'b0, 2'd2, 1'b1, 32'h3000, 32'h0, 1'b0);
    check("R2 fault before reset", 32'(fault_code), 32'h1);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R11 fault after reset", 32'(fault_code), 32'h0);
    check("R11 rsp_valid after reset", 32'(rsp_valid), 32'h0);
    rst = 1'b0;

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule